// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small processor core and decides which of five interrupt sources is serviced next. The sources are a non-maskable trap, three restart lines and one general request. The restart lines are labelled 7.5, 6.5 and 5.5 in falling priority. The core pulses a strobe at each instruction boundary. Only on that strobe does the controller look at the sources and grant the winner. It then presents a 16-bit vector address together with a one-cycle take pulse.

The controller holds a global interrupt-enable flag and a mask bit for each restart line. Software sets and clears the flag through dedicated inputs, and accepting any interrupt clears it. The 7.5 line is edge-triggered into a pending latch. The 6.5 and 5.5 lines are level-sensitive. When the bus is lent to another master, every source is held off. A general request supplies its vector externally, so the controller raises an acknowledge instead of producing an address. A status byte shows the controller state and the live sources.

Top module: `vpic_top`

## Requirements
- R1: After reset, take and gen_ack are 0, vec_addr is 0, the enable flag is 0, all three mask bits are 1 (masked) and the 7.5 pending latch is 0.
- R2: When several sources are eligible on the same strobe, exactly one is granted, in this order from highest to lowest: trap, 7.5, 6.5, 5.5, general request.
- R3: A granted trap gives vec_addr 0x0024, 7.5 gives 0x003C, 6.5 gives 0x0034 and 5.5 gives 0x002C.
- R4: The trap is granted regardless of the enable flag and the mask bits.
- R5: A restart line is granted only when the enable flag is 1 and its mask bit is 0. Writing with mask_wr loads mask_data, where bit 2 masks 7.5, bit 1 masks 6.5 and bit 0 masks 5.5.
- R6: The general request is granted only when the enable flag is 1. Its grant raises gen_ack together with take, and vec_addr is 0.
- R7: Sources are sampled only on a clock edge where boundary is 1. The result appears on take, vec_addr and gen_ack in the cycle after that edge and lasts exactly one cycle.
- R8: While bus_held is 1 at the sampling edge, no source is granted, including the trap.
- R9: Any grant clears the enable flag. en_clr clears the flag, and en_set sets it when neither a grant nor en_clr is present.
- R10: A rising edge on the 7.5 input sets its pending latch. The latch stays set after the input falls, and it is cleared by a 7.5 grant or by clr75_pend. An input held high does not set the latch again.
- R11: The 6.5 and 5.5 inputs keep no memory. A pulse that has ended before the strobe is not granted.
- R12: status is {trap_req, rst55_req, rst65_req, 7.5 pending, enable, mask[2:0]} from bit 7 down to bit 0, and it follows its inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_req | input | 1 | Non-maskable trap, level |
| rst75_req | input | 1 | Restart 7.5, edge-triggered |
| rst65_req | input | 1 | Restart 6.5, level |
| rst55_req | input | 1 | Restart 5.5, level |
| gen_req | input | 1 | General request, level |
| boundary | input | 1 | Instruction-boundary sampling strobe |
| bus_held | input | 1 | Bus lent to another master |
| en_set | input | 1 | Software enable |
| en_clr | input | 1 | Software disable |
| mask_wr | input | 1 | Load the mask bits |
| mask_data | input | 3 | New mask bits (1 = masked) |
| clr75_pend | input | 1 | Software clear of the 7.5 pending latch |
| take | output | 1 | One-cycle grant pulse |
| vec_addr | output | 16 | Vector address of the granted source |
| gen_ack | output | 1 | General request accepted |
| status | output | 8 | Readable state and live sources |

## Verification
Grant outputs are registered. They change one clock after the strobe edge that sampled the sources and fall back one clock later. The status byte is combinational and follows its inputs in the same cycle. Each step of the bench drives inputs at a falling edge and samples at the falling edge that follows the next rising edge, so grant results are read in the cycle they are due. Status is read a moment after it is driven, inside the same low phase. The pulse width and the pending-latch behaviour are checked in the cycle after the grant.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int VEC_W    = 16;
    localparam int NUM_RST  = 3;
    localparam int NUM_SRC  = NUM_RST + 2;
    localparam int SRC_GEN  = 0;
    localparam int SRC_R75  = NUM_RST;
    localparam int SRC_TRAP = NUM_SRC - 1;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0024;
    localparam int VEC_STEP = 8;

    typedef struct packed {
        logic               ie;
        logic [NUM_RST-1:0] mask;
        logic               take;
        logic               ack;
        logic [VEC_W-1:0]   vec;
    } ctl_t;
endpackage

// File: rtl/vpic_edge_latch.sv
module vpic_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic sw_clr,
    input  logic accept,
    output logic seen,
    output logic pend
);
    logic prev_d, prev_q;
    logic pend_d, pend_q;
    logic rise;

    always_comb begin
        rise   = lvl & ~prev_q;
        prev_d = lvl;
        pend_d = (pend_q | rise) & ~(accept | sw_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign seen = pend_q | rise;
    assign pend = pend_q;
endmodule

// File: rtl/vpic_mask_gate.sv
module vpic_mask_gate #(
    parameter int NUM_RST = 3,
    localparam int N = NUM_RST + 2
) (
    input  logic               trap,
    input  logic [NUM_RST-1:0] rst_lvl,
    input  logic               gen,
    input  logic [NUM_RST-1:0] mask,
    input  logic               ie,
    input  logic               bus_held,
    output logic [N-1:0]       elig
);
    assign elig[N-1] = trap & ~bus_held;
    assign elig[0]   = gen & ie & ~bus_held;

    for (genvar i = 0; i < NUM_RST; i++) begin : g_rst
        assign elig[i+1] = rst_lvl[i] & ~mask[i] & ie & ~bus_held;
    end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
    parameter int N = 5,
    parameter int VEC_W = 16,
    parameter logic [VEC_W-1:0] BASE = 16'h0024,
    parameter int STEP = 8
) (
    input  logic [N-1:0]     elig,
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [VEC_W-1:0] vec
);
    logic blocked;

    always_comb begin
        blocked = 1'b0;
        grant   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            grant[i] = elig[i] & ~blocked;
            blocked  = blocked | elig[i];
        end
        any = blocked;
    end

    always_comb begin
        vec = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                if (i == N - 1)
                    vec = BASE;
                else if (i == 0)
                    vec = '0;
                else
                    vec = BASE + VEC_W'(STEP * i);
            end
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              rst75_req,
    input  logic              rst65_req,
    input  logic              rst55_req,
    input  logic              gen_req,
    input  logic              boundary,
    input  logic              bus_held,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              mask_wr,
    input  logic [NUM_RST-1:0] mask_data,
    input  logic              clr75_pend,
    output logic              take,
    output logic [VEC_W-1:0]  vec_addr,
    output logic              gen_ack,
    output logic [7:0]        status
);
    ctl_t ctl_d, ctl_q;

    logic               seen75, pend75;
    logic [NUM_RST-1:0] rst_lvl;
    logic [NUM_SRC-1:0] elig, grant;
    logic               any;
    logic [VEC_W-1:0]   win_vec;
    logic               accept75;

    assign accept75 = boundary & grant[SRC_R75];

    vpic_edge_latch u_lat75 (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (rst75_req),
        .sw_clr (clr75_pend),
        .accept (accept75),
        .seen   (seen75),
        .pend   (pend75)
    );

    assign rst_lvl = {seen75, rst65_req, rst55_req};

    vpic_mask_gate #(.NUM_RST(NUM_RST)) u_gate (
        .trap     (trap_req),
        .rst_lvl  (rst_lvl),
        .gen      (gen_req),
        .mask     (ctl_q.mask),
        .ie       (ctl_q.ie),
        .bus_held (bus_held),
        .elig     (elig)
    );

    vpic_arbiter #(
        .N(NUM_SRC), .VEC_W(VEC_W), .BASE(VEC_BASE), .STEP(VEC_STEP)
    ) u_arb (
        .elig  (elig),
        .grant (grant),
        .any   (any),
        .vec   (win_vec)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.take = 1'b0;
        ctl_d.ack  = 1'b0;
        ctl_d.vec  = '0;
        if (mask_wr)
            ctl_d.mask = mask_data;
        if (boundary && any) begin
            ctl_d.take = 1'b1;
            ctl_d.ack  = grant[SRC_GEN];
            ctl_d.vec  = win_vec;
            ctl_d.ie   = 1'b0;
        end else if (en_clr) begin
            ctl_d.ie = 1'b0;
        end else if (en_set) begin
            ctl_d.ie = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign take     = ctl_q.take;
    assign gen_ack  = ctl_q.ack;
    assign vec_addr = ctl_q.vec;
    assign status   = {trap_req, rst55_req, rst65_req, pend75, ctl_q.ie, ctl_q.mask};
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        boundary,
    input logic        bus_held,
    input logic        trap_req,
    input logic        take,
    input logic        gen_ack,
    input logic [15:0] vec_addr,
    input logic [7:0]  status
);
    a_r7_take_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary));

    a_r8_held_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_held) |-> !take);

    a_r4_trap_vector: assert property (@(posedge clk) disable iff (!rst_n)
        $past(boundary && trap_req && !bus_held) |-> (take && vec_addr == 16'h0024));

    a_r6_ack_form: assert property (@(posedge clk) disable iff (!rst_n)
        gen_ack |-> (take && vec_addr == 16'h0000 && $past(status[3])));

    a_r9_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !status[3]);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take || $past(boundary));
endmodule

bind vpic_top vpic_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .bus_held (bus_held),
    .trap_req (trap_req),
    .take     (take),
    .gen_ack  (gen_ack),
    .vec_addr (vec_addr),
    .status   (status)
);

// File: tb/tb_vpic_top.sv
module tb_vpic_top;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic trap_req = 0, rst75_req = 0, rst65_req = 0, rst55_req = 0, gen_req = 0;
    logic boundary = 0, bus_held = 0, en_set = 0, en_clr = 0, mask_wr = 0, clr75_pend = 0;
    logic [2:0]  mask_data = 3'b000;
    logic        take, gen_ack;
    logic [15:0] vec_addr;
    logic [7:0]  status;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    vpic_top dut (.*);

    // stim {trap,r75,r65,r55,gen}[26:22] mask[21:19] ie[18] | exp take[17] ack[16] vec[15:0]
    localparam logic [26:0] VECS [0:11] = '{
        {5'b11111, 3'b000, 1'b1, 1'b1, 1'b0, 16'h0024},  // R2 R3 trap wins
        {5'b01111, 3'b000, 1'b1, 1'b1, 1'b0, 16'h003C},  // R2 R3 7.5
        {5'b00111, 3'b000, 1'b1, 1'b1, 1'b0, 16'h0034},  // R2 R3 6.5
        {5'b00011, 3'b000, 1'b1, 1'b1, 1'b0, 16'h002C},  // R2 R3 5.5
        {5'b00001, 3'b000, 1'b1, 1'b1, 1'b1, 16'h0000},  // R6 general
        {5'b00001, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0000},  // R6 ie off
        {5'b01100, 3'b100, 1'b1, 1'b1, 1'b0, 16'h0034},  // R5 7.5 masked
        {5'b00010, 3'b001, 1'b1, 1'b0, 1'b0, 16'h0000},  // R5 5.5 masked
        {5'b10000, 3'b111, 1'b0, 1'b1, 1'b0, 16'h0024},  // R4 trap ignores mask/ie
        {5'b00110, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0000},  // R5 ie off
        {5'b01001, 3'b100, 1'b1, 1'b1, 1'b1, 16'h0000},  // R5 R6
        {5'b00110, 3'b010, 1'b1, 1'b1, 1'b0, 16'h002C}   // R5 6.5 masked
    };

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(logic [2:0] m, logic ie);
        mask_wr = 1; mask_data = m; en_set = ie; en_clr = !ie; clr75_pend = 1;
        tick;
        mask_wr = 0; en_set = 0; en_clr = 0; clr75_pend = 0;
    endtask

    task automatic drop;
        {trap_req, rst75_req, rst65_req, rst55_req, gen_req} = '0;
        boundary = 0; bus_held = 0;
        tick;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        tick; tick;
        rst_n = 1;
        #1;
        // R1 R12 reset state
        chk("R1 take", 32'(take), 0);
        chk("R1 ack", 32'(gen_ack), 0);
        chk("R1 vec", 32'(vec_addr), 0);
        chk("R1 R12 status", 32'(status), 32'h07);
        tick;

        for (int i = 0; i < 12; i++) begin
            setup(VECS[i][21:19], VECS[i][18]);
            {trap_req, rst75_req, rst65_req, rst55_req, gen_req} = VECS[i][26:22];
            boundary = 1;
            tick;
            chk($sformatf("R2 vec%0d take", i), 32'(take), 32'(VECS[i][17]));
            chk($sformatf("R6 vec%0d ack", i), 32'(gen_ack), 32'(VECS[i][16]));
            chk($sformatf("R3 vec%0d addr", i), 32'(vec_addr), 32'(VECS[i][15:0]));
            drop();
        end

        // R7 no strobe, no grant
        setup(3'b000, 1);
        trap_req = 1;
        tick;
        chk("R7 no strobe", 32'(take), 0);
        drop();

        // R10 edge remembered, R7 single pulse, R9 ie cleared
        setup(3'b000, 1);
        rst75_req = 1; tick;
        chk("R10 pend set", 32'(status[4]), 1);
        rst75_req = 0; tick;
        boundary = 1; tick;
        chk("R10 latched grant", 32'(vec_addr), 32'h3C);
        chk("R10 take", 32'(take), 1);
        boundary = 0; tick;
        chk("R7 pulse ends", 32'(take), 0);
        chk("R10 pend cleared", 32'(status[4]), 0);
        chk("R9 ie cleared", 32'(status[3]), 0);

        // R10 held level does not re-pend
        setup(3'b000, 1);
        rst75_req = 1; boundary = 1; tick;
        chk("R10 first grant", 32'(vec_addr), 32'h3C);
        boundary = 0; en_set = 1; tick;
        en_set = 0; boundary = 1; tick;
        chk("R10 no repend", 32'(take), 0);
        drop();

        // R10 software clear
        setup(3'b000, 1);
        rst75_req = 1; tick;
        rst75_req = 0; tick;
        clr75_pend = 1; tick;
        clr75_pend = 0;
        chk("R10 sw clear", 32'(status[4]), 0);
        boundary = 1; tick;
        chk("R10 cleared no grant", 32'(take), 0);
        drop();

        // R11 level line has no memory
        setup(3'b000, 1);
        rst65_req = 1; tick;
        rst65_req = 0; boundary = 1; tick;
        chk("R11 no memory", 32'(take), 0);
        drop();

        // R8 bus held blocks trap
        setup(3'b000, 1);
        trap_req = 1; bus_held = 1; boundary = 1; tick;
        chk("R8 held", 32'(take), 0);
        bus_held = 0; tick;
        chk("R8 released", 32'(vec_addr), 32'h24);
        drop();

        // R9 software disable
        setup(3'b000, 1);
        en_clr = 1; tick;
        en_clr = 0;
        chk("R9 en_clr", 32'(status[3]), 0);
        rst55_req = 1; boundary = 1; tick;
        chk("R9 disabled no grant", 32'(take), 0);
        drop();

        // R12 status layout
        setup(3'b101, 1);
        trap_req = 1; rst65_req = 1; rst55_req = 1;
        #1;
        chk("R12 status", 32'(status), 32'hED);
        drop();

        finish_run();
    end
endmodule